// File: doc/BRIEF.md
# Bidirectional Interrupt Pin Crosspoint Controller

This block looks after four shared interrupt request lines. Each line is wired-AND and pulled high. At run time, software picks one of four modes for each line: idle, low-active driver, falling-edge receiver or low-level receiver. A receiving line passes through a two-stage synchroniser and then a detector. Each detected event is latched in a write-one-to-clear status bit, one bit per line.

A 4x4 enable matrix connects receiving lines to driving lines. A driving line pulls low while any status bit routed to it is set. One driving line is named the destination for the block's internal request sources. That line pulls low while any internal source is high, and the matrix has no effect on it. An event is latched only if it is routed to at least one driving line that is not the destination.

A small register port carries configuration and status. Writes take effect on the clock edge. Reads are combinational.

Top module: `irq_xbar_ctrl`

## Requirements
- R1: After reset, every line is idle, the route matrix is zero, the destination field is 0 and the status is zero. No line is driven.
- R2: Each line has a 2-bit mode at configuration bits [2i+1:2i]: 00 idle, 01 driver, 10 falling-edge receiver, 11 low-level receiver. A line in any mode other than 01 is never driven (pin_oe low).
- R3: In mode 10, a high-to-low transition of the line sets its status bit on the third rising clock edge after the change. If the bit is cleared while the line stays low, it stays clear.
- R4: In mode 11, the status bit is set while the line is low. A clear issued while the line is still low leaves the bit set.
- R5: A status bit stays set until a write to address 2 has a 1 in that bit's position. Writing 0 to a bit leaves it unchanged.
- R6: A driving line o other than the destination is driven (pin_oe[o]=1, pin_out[o]=0) while any status bit i with route bit 4*o+i set is 1. It is released in the cycle after the last such bit is cleared.
- R7: The destination line is selected by configuration bits [9:8]. If that line is in mode 01, it is driven exactly while any irq_src bit is high. Route bits that target it have no effect.
- R8: An event on a receiving line sets no status bit unless the line is routed to at least one driving line that is not the destination.
- R9: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R10: Register map: address 0 holds the configuration (modes [7:0], destination [9:8]), address 1 the route matrix (bit 4*o+i), address 2 the status ([3:0], write-one-to-clear). Address 0 and address 1 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| irq_src | input | 3 | Internal request sources, active high |
| pin_in | input | 4 | Sensed level of each line |
| pin_out | output | 4 | Drive value of each line (always low) |
| pin_oe | output | 4 | Driver enable of each line |

## Verification
Assertions check on every cycle that idle and receiving lines are never driven, and that the destination line follows the internal sources. They also check that a set status bit holds until a clear, that an unrouted line never sets its bit, and that a routed event always sets its bit. The bench scenarios cover the timing-dependent behaviour: synchroniser latency, an edge receiver staying clear while the line is held low, a level receiver re-setting its bit after a clear, an event landing in the same cycle as a clear, and random mixes of modes, routes and line levels checked against a model in the bench.

// File: rtl/irq_xbar_pkg.sv
`timescale 1ns/1ps
package irq_xbar_pkg;
    localparam int NPINS = 4;
    localparam int SELW  = $clog2(NPINS);
    localparam int NSRC  = 3;
    localparam int DW    = 16;
    localparam int AW    = 2;

    localparam logic [AW-1:0] ADDR_CFG   = 2'd0;
    localparam logic [AW-1:0] ADDR_ROUTE = 2'd1;
    localparam logic [AW-1:0] ADDR_STAT  = 2'd2;

    typedef enum logic [1:0] {
        PM_IDLE  = 2'b00,
        PM_DRIVE = 2'b01,
        PM_FALL  = 2'b10,
        PM_LOW   = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic [SELW-1:0]              dest;
        pin_mode_e [NPINS-1:0]        mode;
    } cfg_t;

    localparam int CFGW = $bits(cfg_t);

    typedef logic [NPINS-1:0][NPINS-1:0] route_t;

    function automatic logic is_receiver(pin_mode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/irq_pin_detect.sv
`timescale 1ns/1ps
module irq_pin_detect
    import irq_xbar_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_in,
    input  pin_mode_e mode,
    output logic      event_o
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= pin_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    always_comb begin
        unique case (mode)
            PM_FALL: event_o = prev_q & ~s2_q;
            PM_LOW:  event_o = ~s2_q;
            default: event_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_xbar_route.sv
`timescale 1ns/1ps
module irq_xbar_route
    import irq_xbar_pkg::*;
(
    input  cfg_t              cfg,
    input  route_t            route,
    input  logic [NPINS-1:0]  status,
    input  logic [NSRC-1:0]   irq_src,
    output logic [NPINS-1:0]  routed,
    output logic [NPINS-1:0]  drive
);
    logic [NPINS-1:0] mirror_out;

    always_comb begin
        for (int o = 0; o < NPINS; o++) begin
            mirror_out[o] = (cfg.mode[o] == PM_DRIVE) && (SELW'(o) != cfg.dest);
        end
        for (int i = 0; i < NPINS; i++) begin
            routed[i] = 1'b0;
            for (int o = 0; o < NPINS; o++) begin
                routed[i] = routed[i] | (mirror_out[o] & route[o][i]);
            end
            routed[i] = routed[i] & is_receiver(cfg.mode[i]);
        end
        for (int o = 0; o < NPINS; o++) begin
            if (cfg.mode[o] != PM_DRIVE)
                drive[o] = 1'b0;
            else if (SELW'(o) == cfg.dest)
                drive[o] = |irq_src;
            else
                drive[o] = |(route[o] & status);
        end
    end
endmodule

// File: rtl/irq_xbar_regs.sv
`timescale 1ns/1ps
module irq_xbar_regs
    import irq_xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [NPINS-1:0]  events,
    input  logic [NPINS-1:0]  routed,
    output cfg_t              cfg,
    output route_t            route,
    output logic [NPINS-1:0]  status
);
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] post;

    assign clr  = (wr_en && wr_addr == ADDR_STAT) ? wr_data[NPINS-1:0] : '0;
    assign post = events & routed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            route  <= '0;
            status <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_CFG)
                cfg <= cfg_t'(wr_data[CFGW-1:0]);
            if (wr_en && wr_addr == ADDR_ROUTE)
                route <= route_t'(wr_data[NPINS*NPINS-1:0]);
            status <= (status & ~clr) | post;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CFG:   rd_data[CFGW-1:0]        = cfg;
            ADDR_ROUTE: rd_data[NPINS*NPINS-1:0] = route;
            ADDR_STAT:  rd_data[NPINS-1:0]       = status;
            default:    rd_data = '0;
        endcase
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !clr[i]) |=> status[i]); // R5
        AST_UNROUTED_SILENT: assert property (@(posedge clk) disable iff (rst)
            (!status[i] && !routed[i]) |=> !status[i]); // R8
        AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
            (events[i] && routed[i] && clr[i]) |=> status[i]); // R9
    end
endmodule

// File: rtl/irq_xbar_ctrl.sv
`timescale 1ns/1ps
module irq_xbar_ctrl
    import irq_xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [NSRC-1:0]   irq_src,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);
    cfg_t             cfg;
    route_t           route;
    logic [NPINS-1:0] status;
    logic [NPINS-1:0] events;
    logic [NPINS-1:0] routed;
    logic [NPINS-1:0] drive;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        irq_pin_detect i_det (
            .clk     (clk),
            .rst     (rst),
            .pin_in  (pin_in[i]),
            .mode    (cfg.mode[i]),
            .event_o (events[i])
        );

        AST_IDLE_TRISTATE: assert property (@(posedge clk) disable iff (rst)
            (cfg.mode[i] != PM_DRIVE) |-> !pin_oe[i]); // R2
    end

    irq_xbar_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .events  (events),
        .routed  (routed),
        .cfg     (cfg),
        .route   (route),
        .status  (status)
    );

    irq_xbar_route i_route (
        .cfg     (cfg),
        .route   (route),
        .status  (status),
        .irq_src (irq_src),
        .routed  (routed),
        .drive   (drive)
    );

    assign pin_oe  = drive;
    assign pin_out = '0;

    AST_DEST_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode[cfg.dest] == PM_DRIVE) |-> (pin_oe[cfg.dest] == |irq_src)); // R7
endmodule

// File: tb/test_irq_xbar_ctrl.sv
`timescale 1ns/1ps
module test_irq_xbar_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  irq_src = '0;
    logic [3:0]  ext = 4'hF;
    logic [3:0]  pin_in;
    logic [3:0]  pin_out;
    logic [3:0]  pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign pin_in = ext & ~pin_oe;

    irq_xbar_ctrl i_irq_xbar_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_src(irq_src),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [3:0] exp_routed(logic [15:0] cfg, logic [15:0] rt);
        logic [3:0] r = '0;
        for (int i = 0; i < 4; i++)
            for (int o = 0; o < 4; o++)
                if (cfg[2*i+1] && cfg[2*o +: 2] == 2'b01 && o != int'(cfg[9:8]) && rt[4*o+i])
                    r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [3:0] exp_oe(logic [15:0] cfg, logic [15:0] rt,
                                          logic [3:0] st, logic [2:0] src);
        logic [3:0] r = '0;
        for (int o = 0; o < 4; o++)
            if (cfg[2*o +: 2] == 2'b01)
                r[o] = (o == int'(cfg[9:8])) ? |src : |(rt[4*o +: 4] & st);
        return r;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] cfg, rt;
        logic [3:0]  est;
        void'($urandom(32'd1234));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        rd(0, d); check("R1 cfg", d, 16'h0);
        rd(1, d); check("R1 route", d, 16'h0);
        rd(2, d); check("R1 status", d, 16'h0);
        check("R1 oe", {12'h0, pin_oe}, 16'h0);

        // R10 config: pin0 edge, pin1 level, pin2/3 drivers, dest=3
        cfg = 16'h035E; rt = 16'h0300;
        wr(0, cfg); wr(1, rt);
        rd(0, d); check("R10 cfg readback", d, cfg);
        rd(1, d); check("R10 route readback", d, rt);

        // R7 destination follows internal sources
        irq_src = 3'b100; #1;
        check("R7 dest driven", {12'h0, pin_oe}, 16'h8);
        irq_src = 3'b000; #1;
        check("R7 dest released", {12'h0, pin_oe}, 16'h0);

        // R3 edge detect latency and R6 mirror drive
        ext[0] = 1'b0;
        tick(2);
        rd(2, d); check("R3 not yet set", d, 16'h0);
        tick(1);
        rd(2, d); check("R3 edge sets status", d, 16'h1);
        check("R6 mirror drives", {12'h0, pin_oe}, 16'h4);
        ext[0] = 1'b1;
        tick(3);
        // R5 sticky: zero write and other-bit write leave it
        wr(2, 16'h0); rd(2, d); check("R5 zero write", d, 16'h1);
        wr(2, 16'h2); rd(2, d); check("R5 other bit", d, 16'h1);
        wr(2, 16'h1); rd(2, d); check("R5 clear", d, 16'h0);
        check("R6 released", {12'h0, pin_oe}, 16'h0);

        // R3 no retrigger while held low
        ext[0] = 1'b0; tick(4);
        wr(2, 16'h1); tick(3);
        rd(2, d); check("R3 held low no retrigger", d, 16'h0);
        ext[0] = 1'b1; tick(3);

        // R9 event coincides with clear
        ext[0] = 1'b0; tick(4);
        ext[0] = 1'b1; tick(3);
        rd(2, d); check("R9 setup", d, 16'h1);
        ext[0] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(2, 16'h1);
        rd(2, d); check("R9 event wins", d, 16'h1);
        ext[0] = 1'b1; tick(3);
        wr(2, 16'h1);

        // R4 level re-sets after clear while low
        ext[1] = 1'b0; tick(3);
        rd(2, d); check("R4 level sets", d, 16'h2);
        wr(2, 16'h2); rd(2, d); check("R4 clear while low", d, 16'h2);
        ext[1] = 1'b1; tick(3);
        rd(2, d); check("R4 sticky after release", d, 16'h2);
        wr(2, 16'h2); rd(2, d); check("R4 cleared", d, 16'h0);

        // R8 unrouted input posts nothing
        wr(1, 16'h0100);
        ext[1] = 1'b0; tick(4);
        rd(2, d); check("R8 unrouted status", d, 16'h0);
        check("R8 unrouted oe", {12'h0, pin_oe}, 16'h0);
        ext[1] = 1'b1; tick(3);

        // R7 route to destination only is ignored
        wr(1, 16'h1000);
        ext[0] = 1'b0; tick(4);
        rd(2, d); check("R7 dest route status", d, 16'h0);
        check("R7 dest route oe", {12'h0, pin_oe}, 16'h0);
        ext[0] = 1'b1; tick(3);

        // R2 driver disabled by mode change
        wr(1, 16'h0200);
        ext[1] = 1'b0; tick(4);
        check("R2 driver active", {12'h0, pin_oe}, 16'h4);
        wr(0, 16'h034E);
        check("R2 idle not driven", {12'h0, pin_oe}, 16'h0);
        ext[1] = 1'b1; tick(3);
        wr(2, 16'hF);

        // random mixes (R2 R6 R7 R8)
        for (int n = 0; n < 60; n++) begin
            ext = 4'hF; irq_src = '0;
            cfg = {6'h0, 2'($urandom), 8'($urandom)};
            rt  = 16'($urandom);
            wr(0, cfg); wr(1, rt);
            tick(4);
            wr(2, 16'hF);
            tick(1);
            ext = 4'($urandom);
            irq_src = 3'($urandom);
            tick(5);
            est = '0;
            for (int i = 0; i < 4; i++)
                est[i] = !ext[i] && exp_routed(cfg, rt)[i];
            rd(2, d); check("R8 random status", d, {12'h0, est});
            check("R6 random oe", {12'h0, pin_oe}, {12'h0, exp_oe(cfg, rt, est, irq_src)});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule